// File: doc/BRIEF.md
# RDS Bit Buffer with Master and Slave Readout

This block sits behind an RDS/RBDS demodulator and keeps the decoded data bits in a 128-entry bit memory until a host collects them. The demodulator hands over one bit per strobe, together with a signal-quality flag that says an RDS carrier is present. The host reads the stored bits over a two-wire link of a clock and a data line. The direction of that clock line depends on the selected readout mode. In master readout the block drives the clock itself, with equal high and low phases, and the host samples data on each falling edge. In slave readout the host drives the clock and a status line tells it whether unread bits are waiting.

Two select inputs choose among four modes: master readout, slave readout, standby and a reserved test mode. In standby and in test mode the block is frozen. A channel-clear input rearms the quality gate, so no bit is stored after a clear until the first quality detect. In slave mode the clear also empties the memory. After a clear in master mode, the clock and data lines stay high until quality is detected. The memory is a circular buffer. When it overflows, the oldest unread bit is dropped. A change from master to slave during a stream continues with the bit that follows the last one delivered.

Top module: `rds_bitbuf`

## Requirements
- R1: Mode decode: with test_sel=0 and mode_sel=0 (master) bclk_oe is 1. With test_sel=0 and mode_sel=1 (slave) bclk_oe is 0 and status carries READY. With test_sel=1 (standby when mode_sel=0, test when mode_sel=1) bclk_oe, bclk_out, bdata and status are all 0.
- R2: After power-on reset or a chan_clr pulse, strobed bits are not stored until qual_det has been seen high. From then on they are stored even while qual_det is low. A qual_det pulse on its own stores nothing.
- R3: In master mode after reset or chan_clr, bclk_out and bdata are 1 from the cycle after the clear until one cycle after the quality gate opens. The block then idles with bclk_out at 0.
- R4: In master mode, each stored bit is delivered in store order. bdata takes the new bit as bclk_out rises. bclk_out stays high for HALF_CYC cycles and, when more bits are waiting, low for HALF_CYC cycles. bdata is stable across each falling edge.
- R5: In slave mode, status (READY) is 1 exactly while unread bits remain, and bdata shows the oldest unread bit (0 when empty). The bit is valid across both edges of bclk_in. Each falling edge of bclk_in, after a two-flop synchronizer, consumes one bit.
- R6: Once DEPTH bits are unread, a further store drops the oldest one, so the buffer holds the newest DEPTH bits in order.
- R7: chan_clr in slave mode empties the buffer, and READY is 0 in the following cycle.
- R8: After a switch from master to slave following the falling edge that delivered bit n, slave readout begins with bit n+1.
- R9: In standby and in test mode, strobes are not stored and bclk_in edges consume nothing. The buffer contents and read position are the same on return.
- R10: In master mode, status is qual_det delayed by one cycle, and it is forced to 0 while chan_clr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low |
| bit_stb | input | 1 | One-cycle strobe, a demodulated bit is present |
| bit_val | input | 1 | Demodulated data bit |
| qual_det | input | 1 | RDS signal-quality detect |
| test_sel | input | 1 | Mode select, high selects standby or test |
| mode_sel | input | 1 | Mode select, high selects slave (or test) |
| chan_clr | input | 1 | Channel clear, active high |
| bclk_in | input | 1 | Host readout clock (slave mode) |
| bclk_out | output | 1 | Driven readout clock (master mode) |
| bclk_oe | output | 1 | Output enable for the readout clock line |
| bdata | output | 1 | Readout data bit |
| status | output | 1 | Quality flag in master mode, READY in slave mode |

## Verification
The bench first sends strobes before any quality detect and after a clear. A design that did not gate on the quality flag would raise READY or start streaming on stale bits. It overfills the buffer by two bits and reads back exactly 128. A design that stalled or dropped the wrong end would show a mismatch against the scoreboard or a wrong READY at the end of the read. It switches from master to slave right after the third falling edge of a six-bit stream. Losing or repeating a bit at the switch would misalign every remaining slave read. It also toggles the host clock and strobes bits in standby. A design that kept running there would consume bits or store new ones.

// File: rtl/rds_bitbuf_pkg.sv
package rds_bitbuf_pkg;

    typedef enum logic [1:0] {
        OP_MASTER  = 2'd0,
        OP_SLAVE   = 2'd1,
        OP_STANDBY = 2'd2,
        OP_TEST    = 2'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        M_HOLD = 2'd0,
        M_WAIT = 2'd1,
        M_HIGH = 2'd2,
        M_LOW  = 2'd3
    } mstate_e;

endpackage

// File: rtl/rds_mode_dec.sv
module rds_mode_dec
    import rds_bitbuf_pkg::*;
(
    input  logic     test_sel,
    input  logic     mode_sel,
    output op_mode_e op
);

    always_comb begin
        unique case ({test_sel, mode_sel})
            2'b00:   op = OP_MASTER;
            2'b01:   op = OP_SLAVE;
            2'b10:   op = OP_STANDBY;
            default: op = OP_TEST;
        endcase
    end

endmodule

// File: rtl/rds_ring.sv
module rds_ring #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          run_en,
    input  logic          clear,
    input  logic          push,
    input  logic          push_bit,
    input  logic          pop,
    output logic          head_bit,
    output logic          nonempty,
    output logic [CW-1:0] count
);

    logic [DEPTH-1:0] mem_q;
    logic [AW-1:0]    wp_q;
    logic [AW-1:0]    rp_q;
    logic [CW-1:0]    cnt_q;
    logic             full;
    logic             do_pop;
    logic             adv_rd;
    logic             inc;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (cnt_q == CW'(DEPTH));
    assign nonempty = (cnt_q != '0);
    assign do_pop   = pop & nonempty;
    assign adv_rd   = do_pop | (push & full);
    assign inc      = push & (~full | do_pop);
    assign head_bit = mem_q[rp_q];
    assign count    = cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mem_q <= '0;
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (run_en) begin
            if (clear) begin
                wp_q  <= '0;
                rp_q  <= '0;
                cnt_q <= '0;
            end else begin
                if (push) begin
                    mem_q[wp_q] <= push_bit;
                    wp_q        <= bump(wp_q);
                end
                if (adv_rd) begin
                    rp_q <= bump(rp_q);
                end
                cnt_q <= cnt_q + CW'(inc) - CW'(do_pop);
            end
        end
    end

endmodule

// File: rtl/rds_slave_rd.sv
module rds_slave_rd #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic run_en,
    input  logic slave_en,
    input  logic host_clk,
    output logic fall_stb
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else if (run_en) begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], host_clk};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall_stb = run_en & slave_en & prev_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/rds_master_fsm.sv
module rds_master_fsm
    import rds_bitbuf_pkg::*;
#(
    parameter int HALF_CYC = 1823,
    localparam int CTW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
    input  logic clk,
    input  logic por_n,
    input  logic run_en,
    input  logic master_en,
    input  logic clr_req,
    input  logic armed,
    input  logic avail,
    input  logic head_bit,
    output logic pop,
    output logic clk_o,
    output logic dat_o
);

    mstate_e        st_q;
    mstate_e        st_d;
    logic [CTW-1:0] cnt_q;
    logic           dat_q;
    logic           pop_c;
    logic           phase_end;

    assign phase_end = (cnt_q == CTW'(HALF_CYC - 1));
    assign pop       = pop_c & run_en;

    // next state and pop request
    always_comb begin
        st_d  = st_q;
        pop_c = 1'b0;
        if (clr_req) begin
            st_d = M_HOLD;
        end else begin
            unique case (st_q)
                M_HOLD: begin
                    if (armed) st_d = M_WAIT;
                end
                M_WAIT: begin
                    if (master_en && avail) begin
                        st_d  = M_HIGH;
                        pop_c = 1'b1;
                    end
                end
                M_HIGH: begin
                    if (!master_en)     st_d = M_WAIT;
                    else if (phase_end) st_d = M_LOW;
                end
                M_LOW: begin
                    if (!master_en) begin
                        st_d = M_WAIT;
                    end else if (phase_end) begin
                        if (avail) begin
                            st_d  = M_HIGH;
                            pop_c = 1'b1;
                        end else begin
                            st_d = M_WAIT;
                        end
                    end
                end
            endcase
        end
    end

    // state register, phase counter and data latch
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q  <= M_HOLD;
            cnt_q <= '0;
            dat_q <= 1'b1;
        end else if (run_en) begin
            st_q <= st_d;
            if (st_d != st_q)                          cnt_q <= '0;
            else if (st_q == M_HIGH || st_q == M_LOW)  cnt_q <= cnt_q + 1'b1;
            if (clr_req || st_q == M_HOLD)             dat_q <= 1'b1;
            else if (pop_c)                            dat_q <= head_bit;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            M_HOLD:  begin clk_o = 1'b1; dat_o = 1'b1;  end
            M_HIGH:  begin clk_o = 1'b1; dat_o = dat_q; end
            default: begin clk_o = 1'b0; dat_o = dat_q; end
        endcase
    end

endmodule

// File: rtl/rds_bitbuf.sv
module rds_bitbuf
    import rds_bitbuf_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int HALF_CYC    = 1823,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic por_n,
    input  logic bit_stb,
    input  logic bit_val,
    input  logic qual_det,
    input  logic test_sel,
    input  logic mode_sel,
    input  logic chan_clr,
    input  logic bclk_in,
    output logic bclk_out,
    output logic bclk_oe,
    output logic bdata,
    output logic status
);

    op_mode_e         op;
    logic             is_master;
    logic             is_slave;
    logic             run_en;
    logic             armed_q;
    logic             id_q;
    logic             wr_push;
    logic             rd_pop;
    logic             m_pop;
    logic             s_fall;
    logic             head_bit;
    logic             nonempty;
    logic [CNT_W-1:0] fill_cnt;
    logic             m_clk;
    logic             m_dat;

    rds_mode_dec u_dec (
        .test_sel (test_sel),
        .mode_sel (mode_sel),
        .op       (op)
    );

    assign is_master = (op == OP_MASTER);
    assign is_slave  = (op == OP_SLAVE);
    assign run_en    = is_master | is_slave;

    // quality gate and quality flag
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            armed_q <= 1'b0;
            id_q    <= 1'b0;
        end else if (run_en) begin
            if (chan_clr)      armed_q <= 1'b0;
            else if (qual_det) armed_q <= 1'b1;
            id_q <= qual_det & ~chan_clr;
        end
    end

    assign wr_push = run_en & bit_stb & armed_q & ~chan_clr;
    assign rd_pop  = m_pop | s_fall;

    rds_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .por_n    (por_n),
        .run_en   (run_en),
        .clear    (is_slave & chan_clr),
        .push     (wr_push),
        .push_bit (bit_val),
        .pop      (rd_pop),
        .head_bit (head_bit),
        .nonempty (nonempty),
        .count    (fill_cnt)
    );

    rds_master_fsm #(.HALF_CYC(HALF_CYC)) u_mfsm (
        .clk       (clk),
        .por_n     (por_n),
        .run_en    (run_en),
        .master_en (is_master),
        .clr_req   (chan_clr),
        .armed     (armed_q),
        .avail     (nonempty),
        .head_bit  (head_bit),
        .pop       (m_pop),
        .clk_o     (m_clk),
        .dat_o     (m_dat)
    );

    rds_slave_rd #(.SYNC_STAGES(SYNC_STAGES)) u_srd (
        .clk      (clk),
        .por_n    (por_n),
        .run_en   (run_en),
        .slave_en (is_slave),
        .host_clk (bclk_in),
        .fall_stb (s_fall)
    );

    always_comb begin
        unique case (op)
            OP_MASTER: begin
                bclk_oe  = 1'b1;
                bclk_out = m_clk;
                bdata    = m_dat;
                status   = id_q;
            end
            OP_SLAVE: begin
                bclk_oe  = 1'b0;
                bclk_out = 1'b0;
                bdata    = nonempty & head_bit;
                status   = nonempty;
            end
            default: begin
                bclk_oe  = 1'b0;
                bclk_out = 1'b0;
                bdata    = 1'b0;
                status   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rds_bitbuf_chk.sv
module rds_bitbuf_chk #(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          por_n,
    input logic          test_sel,
    input logic          mode_sel,
    input logic          chan_clr,
    input logic          qual_det,
    input logic          bit_stb,
    input logic          bclk_oe,
    input logic          bclk_out,
    input logic          bdata,
    input logic          status,
    input logic          armed,
    input logic          push,
    input logic [CW-1:0] count
);

    logic in_master;
    logic in_slave;
    assign in_master = !test_sel && !mode_sel;
    assign in_slave  = !test_sel && mode_sel;

    assert_oe_decode_R1: assert property (@(posedge clk) disable iff (!por_n)
        bclk_oe == in_master);

    assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!por_n)
        test_sel |-> (!bclk_oe && !bclk_out && !bdata && !status));

    assert_no_store_unarmed_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!armed && !qual_det && bit_stb) |=> !(count > $past(count)));

    assert_hold_after_clr_R3: assert property (@(posedge clk) disable iff (!por_n)
        (chan_clr && in_master) |=> (!in_master || (bclk_out && bdata)));

    assert_data_stable_fall_R4: assert property (@(posedge clk) disable iff (!por_n)
        (in_master && $past(in_master) && $fell(bclk_out)) |-> $stable(bdata));

    assert_full_keeps_R6: assert property (@(posedge clk) disable iff (!por_n)
        (count == CW'(DEPTH) && push) |=> (count == CW'(DEPTH)));

    assert_ready_clear_R7: assert property (@(posedge clk) disable iff (!por_n)
        (chan_clr && in_slave) |=> (!in_slave || !status));

    assert_frozen_standby_R9: assert property (@(posedge clk) disable iff (!por_n)
        test_sel |=> $stable(count));

endmodule

bind rds_bitbuf rds_bitbuf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .test_sel (test_sel),
    .mode_sel (mode_sel),
    .chan_clr (chan_clr),
    .qual_det (qual_det),
    .bit_stb  (bit_stb),
    .bclk_oe  (bclk_oe),
    .bclk_out (bclk_out),
    .bdata    (bdata),
    .status   (status),
    .armed    (armed_q),
    .push     (wr_push),
    .count    (fill_cnt)
);

// File: tb/rds_bitbuf_test.sv
module rds_bitbuf_test;

    localparam int DEPTH = 128;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic por_n, bit_stb, bit_val, qual_det, test_sel, mode_sel, chan_clr, bclk_in;
    logic bclk_out, bclk_oe, bdata, status;

    always #2 clk = ~clk;

    rds_bitbuf #(.DEPTH(DEPTH), .HALF_CYC(HALF), .SYNC_STAGES(2)) uut (
        .clk(clk), .por_n(por_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .qual_det(qual_det), .test_sel(test_sel), .mode_sel(mode_sel),
        .chan_clr(chan_clr), .bclk_in(bclk_in), .bclk_out(bclk_out),
        .bclk_oe(bclk_oe), .bdata(bdata), .status(status)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    bit  exp_q[$];
    bit  armed_m = 0;

    bit  mon_en = 0;
    bit  chk_low = 0;
    bit  have_fall = 0;
    bit  prev_c = 0;
    int  hi_run = 0;
    int  lo_run = 0;
    int  mfalls = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: strobe one bit and record it in the scoreboard when it must be kept
    task automatic push_bit(input bit b);
        @(negedge clk);
        bit_stb = 1'b1;
        bit_val = b;
        if (!test_sel && armed_m && !chan_clr) begin
            if (exp_q.size() == DEPTH) void'(exp_q.pop_front());
            exp_q.push_back(b);
        end
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk);
        qual_det = 1'b1;
        @(negedge clk);
        qual_det = 1'b0;
        armed_m = 1'b1;
    endtask

    // slave host read of one bit, compared against the scoreboard
    task automatic slave_read(input string tag);
        bit e;
        @(negedge clk);
        chk({tag, " READY before read"}, status, 1);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
        chk({tag, " data before rise"}, bdata, e);
        bclk_in = 1'b1;
        repeat (4) @(negedge clk);
        chk({tag, " data before fall"}, bdata, e);
        bclk_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // monitor of master stream
    always @(negedge clk) begin
        if (mon_en) begin
            if (bclk_out && !prev_c) begin
                if (chk_low && have_fall) chk("R4 low phase width", lo_run, HALF);
                hi_run = 1;
            end else if (!bclk_out && prev_c) begin
                chk("R4 high phase width", hi_run, HALF);
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected master bit", 1, 0);
                end else begin
                    chk("R4 master bit order", bdata, exp_q.pop_front());
                end
                mfalls++;
                have_fall = 1;
                lo_run = 1;
            end else if (bclk_out) begin
                hi_run++;
            end else begin
                lo_run++;
            end
        end
        prev_c = bclk_out;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        int reads;
        por_n = 0; bit_stb = 0; bit_val = 0; qual_det = 0;
        test_sel = 0; mode_sel = 0; chan_clr = 0; bclk_in = 0;
        repeat (3) @(negedge clk);
        por_n = 1;
        @(negedge clk);

        // reset state in master mode
        chk("R1 oe in master", bclk_oe, 1);
        chk("R3 clock high after reset", bclk_out, 1);
        chk("R3 data high after reset", bdata, 1);
        chk("R10 status after reset", status, 0);

        // bits before any quality detect are dropped
        for (int i = 0; i < 3; i++) push_bit(i[0]);
        chk("R3 clock still high unarmed", bclk_out, 1);
        @(negedge clk); mode_sel = 1;
        @(negedge clk);
        chk("R1 oe off in slave", bclk_oe, 0);
        chk("R2 READY low with no stores", status, 0);

        // arming stores nothing by itself; later bits stored with quality low
        arm();
        @(negedge clk);
        chk("R2 READY low after arm only", status, 0);
        push_bit(1); push_bit(0); push_bit(1); push_bit(1); push_bit(0);
        @(negedge clk);
        chk("R5 READY with data", status, 1);
        for (int i = 0; i < 5; i++) slave_read("R5 slave read");
        chk("R5 READY low when drained", status, 0);
        chk("R5 data low when drained", bdata, 0);

        // overflow keeps newest DEPTH bits
        for (int i = 0; i < DEPTH + 2; i++) push_bit(((i * 7) ^ (i >> 2)) & 1);
        reads = 0;
        while (exp_q.size() > 0) begin
            slave_read("R6 overflow read");
            reads++;
        end
        chk("R6 reads after overflow", reads, DEPTH);
        chk("R6 READY low after DEPTH reads", status, 0);

        // clear in slave empties buffer and rearms gate
        push_bit(1); push_bit(1); push_bit(0);
        @(negedge clk); chan_clr = 1;
        @(negedge clk); chan_clr = 0;
        exp_q.delete(); armed_m = 0;
        chk("R7 READY low after clear", status, 0);
        push_bit(1); push_bit(0);
        @(negedge clk);
        chk("R2 no store after clear", status, 0);
        arm();

        // standby and test mode freeze the buffer
        push_bit(0); push_bit(1);
        @(negedge clk); test_sel = 1; mode_sel = 0;
        @(negedge clk);
        chk("R1 standby oe", bclk_oe, 0);
        chk("R1 standby status", status, 0);
        chk("R1 standby data", bdata, 0);
        chk("R1 standby clock", bclk_out, 0);
        push_bit(1); push_bit(1);
        bclk_in = 1; repeat (5) @(negedge clk);
        bclk_in = 0; repeat (5) @(negedge clk);
        mode_sel = 1;
        @(negedge clk);
        chk("R1 test mode oe", bclk_oe, 0);
        chk("R1 test mode status", status, 0);
        bclk_in = 1; repeat (5) @(negedge clk);
        bclk_in = 0; repeat (5) @(negedge clk);
        test_sel = 0;
        repeat (2) @(negedge clk);
        slave_read("R9 read after standby");
        slave_read("R9 read after standby");
        chk("R9 nothing stored in standby", status, 0);

        // master streaming
        mode_sel = 0;
        repeat (2) @(negedge clk);
        have_fall = 0; chk_low = 1; mon_en = 1;
        base = mfalls;
        push_bit(1); push_bit(0); push_bit(0); push_bit(1); push_bit(1); push_bit(0);
        wait (exp_q.size() == 0);
        repeat (3 * HALF) @(negedge clk);
        chk_low = 0;
        chk("R4 bits delivered", mfalls - base, 6);

        // master to slave switch mid-stream
        base = mfalls;
        push_bit(0); push_bit(1); push_bit(1); push_bit(0); push_bit(1); push_bit(0);
        wait (mfalls == base + 3);
        @(negedge clk); mode_sel = 1; mon_en = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) slave_read("R8 continue after switch");
        chk("R8 READY low after rest", status, 0);

        // quality flag and clear in master mode
        mode_sel = 0;
        @(negedge clk); qual_det = 1;
        @(negedge clk);
        chk("R10 status follows quality", status, 1);
        qual_det = 0;
        @(negedge clk);
        chk("R10 status drops", status, 0);
        chan_clr = 1;
        @(negedge clk);
        chk("R3 clock high after clear", bclk_out, 1);
        chk("R3 data high after clear", bdata, 1);
        chan_clr = 0; armed_m = 0;
        push_bit(0); push_bit(0);
        repeat (5) @(negedge clk);
        chk("R3 clock held until quality", bclk_out, 1);
        chk("R3 data held until quality", bdata, 1);
        arm();
        repeat (3) @(negedge clk);
        chk("R3 clock idles low after quality", bclk_out, 0);
        repeat (2 * HALF) @(negedge clk);
        chk("R2 no stream of unarmed bits", bclk_out, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule